// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, from the 48-bit destination address of an incoming Ethernet frame, whether the frame is kept and which of eight receive channels it is sent to. It sorts each address into one of four classes. The first is an exact match on the station address, which is gated per channel by a unicast enable mask. The second is broadcast. The third is multicast, which is checked against a 64-entry hash table. The last is a promiscuous catch-all. Each class has its own programmable channel number.

The address enters on a valid/ready stream and the decision leaves on a second valid/ready stream, registered by one stage. The input is accepted when the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While the output is valid and `out_ready` is low, the decision is held unchanged and `in_ready` stays low, so back-pressure passes through without loss. Configuration arrives on plain ports and is sampled in the cycle the address is accepted.

Top module: `rx_addr_filter`

## Requirements
- R1: The hash index is the low 6 bits of the XOR of six per-byte terms. Byte k of the address occupies `in_dst[8k+7:8k]`, and byte 0 is first on the wire. The term for bytes 0 and 3 is `(b>>2)^(b<<4)`, for bytes 1 and 4 it is `(b>>4)^(b<<2)`, and for bytes 2 and 5 it is `(b>>6)^b`, each taken as an 8-bit value. Index i selects bit i of `{cfg_hash_hi, cfg_hash_lo}`, so indices 0–31 fall in the low word.
- R2: An address is multicast when `in_dst[0]` is 1 and the address is not all ones. It is kept as class 3 on channel `cfg_ctrl[2:0]` when `cfg_ctrl[5]` is set and the selected hash bit is 1. With both table words all ones, every multicast address hits.
- R3: An all-ones address is broadcast and never counts as multicast. It is kept as class 2 on channel `cfg_ctrl[10:8]` when `cfg_ctrl[13]` is set.
- R4: When no earlier rule keeps a frame and `cfg_ctrl[21]` is set, the frame is kept as class 4 on channel `cfg_ctrl[18:16]`.
- R5: The station address is `{cfg_sta_lo, cfg_sta_mid, cfg_sta_hi}`, with bytes 0–3 in `cfg_sta_hi` from its low byte upward, byte 4 in `cfg_sta_mid` and byte 5 in `cfg_sta_lo`. An exact match is kept as class 1 on channel `cfg_uc_chan` only when bit `cfg_uc_chan` of `cfg_uc_mask` is set. Otherwise the match is ignored and the later rules apply.
- R6: The rules are applied in a fixed order: station match first, then broadcast, then multicast hash hit, then promiscuous. The class codes are 0 reject, 1 station, 2 broadcast, 3 multicast and 4 promiscuous.
- R7: A frame that no rule keeps gives `out_accept`=0, `out_class`=0 and `out_chan`=0. `out_accept` is 1 exactly when `out_class` is nonzero.
- R8: A decision appears on the output in the cycle after its address is accepted. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` is low.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Destination address present |
| in_ready | output | 1 | Filter can take an address |
| in_dst | input | 48 | Destination address, byte k in bits 8k+7:8k |
| cfg_ctrl | input | 32 | Class enables and channel fields |
| cfg_sta_hi | input | 32 | Station address bytes 0–3 |
| cfg_sta_mid | input | 8 | Station address byte 4 |
| cfg_sta_lo | input | 8 | Station address byte 5 |
| cfg_uc_mask | input | 8 | Per-channel enable for station matches |
| cfg_uc_chan | input | 3 | Channel for station matches |
| cfg_hash_lo | input | 32 | Hash table entries 0–31 |
| cfg_hash_hi | input | 32 | Hash table entries 32–63 |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| out_accept | output | 1 | Frame is kept |
| out_chan | output | 3 | Receive channel |
| out_class | output | 3 | Class code |

## Verification
The block has only one register stage, so every internal fault shows up in the decision for the same address, one cycle after that address is accepted. A wrong fold term or a wrong table-word select moves the hash index, which makes a one-hot table miss or an all-but-one table hit. Sweeping every value of every byte position under both table polarities exposes any misplaced bit of the hash. A wrong priority, or a broken station byte layout or enable mask, changes the class code or the channel. Random configurations that overlap the station, broadcast and multicast cases catch these. A broken hold register shows up as a changed or lost decision while the consumer is stalled.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int CHAN_W    = 3;
  localparam int NUM_CHAN  = 1 << CHAN_W;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W    = ADDR_BYTES * 8;
  localparam int IDX_W     = 6;
  localparam int TABLE_N   = 1 << IDX_W;
  localparam int WORD_W    = 32;

  // control word field positions, decoded by neighbouring logic
  localparam int PROM_EN_BIT = 21;
  localparam int PROM_CH_LSB = 16;
  localparam int BC_EN_BIT   = 13;
  localparam int BC_CH_LSB   = 8;
  localparam int MC_EN_BIT   = 5;
  localparam int MC_CH_LSB   = 0;

  typedef enum logic [2:0] {
    CLS_REJECT  = 3'd0,
    CLS_STATION = 3'd1,
    CLS_BCAST   = 3'd2,
    CLS_MCAST   = 3'd3,
    CLS_PROMISC = 3'd4
  } frame_class_e;

  typedef struct packed {
    logic         accept;
    logic [CHAN_W-1:0] chan;
    frame_class_e cls;
  } verdict_t;

  typedef struct packed {
    logic station_hit;
    logic is_bcast;
    logic is_mcast;
    logic hash_hit;
  } addr_flags_t;
endpackage

// File: rtl/afilt_hash.sv
module afilt_hash
  import afilt_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES,
  parameter int OUT_W  = IDX_W
) (
  input  logic [NBYTES*8-1:0] addr,
  output logic [OUT_W-1:0]    index
);
  logic [7:0] term [NBYTES];

  // each byte folds with a right shift of 2, 4 or 6 (repeating every three
  // bytes) against a left shift that makes the pair sum to six
  for (genvar k = 0; k < NBYTES; k++) begin : g_term
    localparam int RSH = 2 * ((k % 3) + 1);
    localparam int LSH = 6 - RSH;
    logic [7:0] b;
    assign b       = addr[8*k +: 8];
    assign term[k] = (b >> RSH) ^ 8'(b << LSH);
  end

  logic [7:0] fold;
  always_comb begin
    fold = '0;
    for (int k = 0; k < NBYTES; k++) fold = fold ^ term[k];
  end

  assign index = fold[OUT_W-1:0];
endmodule

// File: rtl/afilt_classify.sv
module afilt_classify
  import afilt_pkg::*;
(
  input  logic [ADDR_W-1:0]  dst,
  input  logic [WORD_W-1:0]  sta_hi,
  input  logic [7:0]         sta_mid,
  input  logic [7:0]         sta_lo,
  input  logic [WORD_W-1:0]  hash_lo,
  input  logic [WORD_W-1:0]  hash_hi,
  output addr_flags_t        flags
);
  localparam int NWORDS = TABLE_N / WORD_W;

  logic [ADDR_W-1:0] station;
  logic [IDX_W-1:0]  idx;
  logic [TABLE_N-1:0] table_bits;

  assign station = {sta_lo, sta_mid, sta_hi};

  afilt_hash #(.NBYTES(ADDR_BYTES), .OUT_W(IDX_W)) u_hash (
    .addr  (dst),
    .index (idx)
  );

  // table word w holds entries w*32 .. w*32+31
  logic [WORD_W-1:0] words [NWORDS];
  assign words[0] = hash_lo;
  assign words[1] = hash_hi;
  for (genvar w = 0; w < NWORDS; w++) begin : g_tbl
    assign table_bits[w*WORD_W +: WORD_W] = words[w];
  end

  always_comb begin
    flags.station_hit = (dst == station);
    flags.is_bcast    = &dst;
    flags.is_mcast    = dst[0] && !(&dst);
    flags.hash_hit    = table_bits[idx];
  end
endmodule

// File: rtl/afilt_steer.sv
module afilt_steer
  import afilt_pkg::*;
(
  input  addr_flags_t        flags,
  input  logic [WORD_W-1:0]  ctrl,
  input  logic [NUM_CHAN-1:0] uc_mask,
  input  logic [CHAN_W-1:0]  uc_chan,
  output verdict_t           verdict
);
  logic uc_ok, bc_ok, mc_ok, pr_ok;

  assign uc_ok = flags.station_hit && uc_mask[uc_chan];
  assign bc_ok = flags.is_bcast && ctrl[BC_EN_BIT];
  assign mc_ok = flags.is_mcast && flags.hash_hit && ctrl[MC_EN_BIT];
  assign pr_ok = ctrl[PROM_EN_BIT];

  always_comb begin
    verdict = '{accept: 1'b0, chan: '0, cls: CLS_REJECT};
    if (uc_ok) begin
      verdict = '{accept: 1'b1, chan: uc_chan, cls: CLS_STATION};
    end else if (bc_ok) begin
      verdict = '{accept: 1'b1, chan: ctrl[BC_CH_LSB +: CHAN_W], cls: CLS_BCAST};
    end else if (mc_ok) begin
      verdict = '{accept: 1'b1, chan: ctrl[MC_CH_LSB +: CHAN_W], cls: CLS_MCAST};
    end else if (pr_ok) begin
      verdict = '{accept: 1'b1, chan: ctrl[PROM_CH_LSB +: CHAN_W], cls: CLS_PROMISC};
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import afilt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [47:0]         in_dst,
  input  logic [31:0]         cfg_ctrl,
  input  logic [31:0]         cfg_sta_hi,
  input  logic [7:0]          cfg_sta_mid,
  input  logic [7:0]          cfg_sta_lo,
  input  logic [7:0]          cfg_uc_mask,
  input  logic [2:0]          cfg_uc_chan,
  input  logic [31:0]         cfg_hash_lo,
  input  logic [31:0]         cfg_hash_hi,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_accept,
  output logic [2:0]          out_chan,
  output logic [2:0]          out_class
);
  addr_flags_t flags;
  verdict_t    next_v, held_v;

  afilt_classify u_cls (
    .dst     (in_dst),
    .sta_hi  (cfg_sta_hi),
    .sta_mid (cfg_sta_mid),
    .sta_lo  (cfg_sta_lo),
    .hash_lo (cfg_hash_lo),
    .hash_hi (cfg_hash_hi),
    .flags   (flags)
  );

  afilt_steer u_steer (
    .flags   (flags),
    .ctrl    (cfg_ctrl),
    .uc_mask (cfg_uc_mask),
    .uc_chan (cfg_uc_chan),
    .verdict (next_v)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held_v    <= '{accept: 1'b0, chan: '0, cls: CLS_REJECT};
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) held_v <= next_v;
    end
  end

  assign out_accept = held_v.accept;
  assign out_chan   = held_v.chan;
  assign out_class  = held_v.cls;
endmodule

// File: rtl/rx_addr_filter_checker.sv
module rx_addr_filter_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [47:0] in_dst,
  input logic [31:0] cfg_ctrl,
  input logic [31:0] cfg_sta_hi,
  input logic [7:0]  cfg_sta_mid,
  input logic [7:0]  cfg_sta_lo,
  input logic [7:0]  cfg_uc_mask,
  input logic [2:0]  cfg_uc_chan,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_accept,
  input logic [2:0]  out_chan,
  input logic [2:0]  out_class
);
  logic take;
  assign take = in_valid && in_ready;

  AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_accept)
      && $stable(out_chan) && $stable(out_class)); // R8

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_ACCEPT_MATCHES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_accept == (out_class != 3'd0))); // R7

  AST_REJECT_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |-> out_chan == 3'd0); // R7

  AST_BCAST_NEVER_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (&in_dst)) |=> out_class != 3'd3); // R3

  AST_UNICAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_dst == {cfg_sta_lo, cfg_sta_mid, cfg_sta_hi} && cfg_uc_mask[cfg_uc_chan])
      |=> out_class == 3'd1 && out_chan == $past(cfg_uc_chan)); // R5

  AST_PROMISC_CATCHALL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_ctrl[21]) |=> out_accept); // R4
endmodule

bind rx_addr_filter rx_addr_filter_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_dst      (in_dst),
  .cfg_ctrl    (cfg_ctrl),
  .cfg_sta_hi  (cfg_sta_hi),
  .cfg_sta_mid (cfg_sta_mid),
  .cfg_sta_lo  (cfg_sta_lo),
  .cfg_uc_mask (cfg_uc_mask),
  .cfg_uc_chan (cfg_uc_chan),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_accept  (out_accept),
  .out_chan    (out_chan),
  .out_class   (out_class)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_dst = '0;
  logic [31:0] cfg_ctrl = '0;
  logic [31:0] cfg_sta_hi = '0;
  logic [7:0]  cfg_sta_mid = '0;
  logic [7:0]  cfg_sta_lo = '0;
  logic [7:0]  cfg_uc_mask = '0;
  logic [2:0]  cfg_uc_chan = '0;
  logic [31:0] cfg_hash_lo = '0;
  logic [31:0] cfg_hash_hi = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_accept;
  logic [2:0]  out_chan;
  logic [2:0]  out_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_addr_filter dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_hash(input logic [47:0] a);
    int h = 0;
    for (int k = 0; k < 6; k++) begin
      int b = int'(a[8*k +: 8]);
      int r = 2 * (k % 3 + 1);
      h = h ^ (b >> r) ^ ((b << (6 - r)) & 255);
    end
    return h & 63;
  endfunction

  // expected {accept, chan, class} from the requirements
  function automatic logic [6:0] ref_decide(input logic [47:0] a);
    logic [63:0] tbl = {cfg_hash_hi, cfg_hash_lo};
    bit bc = (a == 48'hFFFF_FFFF_FFFF);
    bit mc = a[0] && !bc;
    if (a == {cfg_sta_lo, cfg_sta_mid, cfg_sta_hi} && cfg_uc_mask[cfg_uc_chan])
      return {1'b1, cfg_uc_chan, 3'd1};
    if (bc && cfg_ctrl[13]) return {1'b1, cfg_ctrl[10:8], 3'd2};
    if (mc && cfg_ctrl[5] && tbl[ref_hash(a)]) return {1'b1, cfg_ctrl[2:0], 3'd3};
    if (cfg_ctrl[21]) return {1'b1, cfg_ctrl[18:16], 3'd4};
    return 7'd0;
  endfunction

  task automatic send_check(input logic [47:0] a, input string req);
    logic [6:0] exp;
    @(negedge clk);
    in_dst = a; in_valid = 1'b1; out_ready = 1'b1;
    exp = ref_decide(a);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, req, 32'(out_valid), 1);
    check({out_accept, out_chan, out_class} === exp, req,
          32'({out_accept, out_chan, out_class}), 32'(exp));
  endtask

  task automatic hash_pair(input logic [47:0] a);
    int idx = ref_hash(a);
    logic [63:0] one = 64'd1 << idx;
    {cfg_hash_hi, cfg_hash_lo} = one;
    send_check(a, "R1 one-hot table hit");
    {cfg_hash_hi, cfg_hash_lo} = ~one;
    send_check(a, "R1 inverted table miss");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0, "R9 out_valid", 32'(out_valid), 0);
    check(in_ready === 1'b1, "R9 in_ready", 32'(in_ready), 1);

    // R1/R2 sweep: every value of every byte position, multicast only on chan 5
    cfg_ctrl = (32'd1 << 5) | 32'd5;
    base = 48'h9A_7C_3E_51_D2_01;
    for (int pos = 0; pos < 6; pos++) begin
      for (int v = 0; v < 256; v++) begin
        logic [47:0] a = base;
        a[8*pos +: 8] = 8'(v);
        a[0] = 1'b1;
        if (a != 48'hFFFF_FFFF_FFFF) hash_pair(a);
      end
    end
    // corner addresses: lone multicast bit, single set bits
    hash_pair(48'h0000_0000_0001);
    for (int k = 1; k < 48; k++) hash_pair((48'd1 << k) | 48'd1);
    // R2 all-ones table accepts any multicast, unicast bit clear misses
    {cfg_hash_hi, cfg_hash_lo} = '1;
    send_check(48'h1234_5678_9A01, "R2 all-ones table");
    send_check(48'h1234_5678_9A02, "R2 non-multicast rejected");
    send_check(48'h0000_0000_0000, "R7 all-zero rejected");

    // R3 broadcast handling
    send_check(48'hFFFF_FFFF_FFFF, "R3 bcast not mcast");
    cfg_ctrl = (32'd1 << 13) | (32'd2 << 8) | (32'd1 << 5) | 32'd5;
    send_check(48'hFFFF_FFFF_FFFF, "R3 bcast accepted");
    // R4 promiscuous catch-all
    cfg_ctrl = (32'd1 << 21) | (32'd6 << 16);
    send_check(48'hFFFF_FFFF_FFFF, "R4 bcast disabled to promisc");
    send_check(48'h0102_0304_0506, "R4 promisc unicast");

    // R5 station matching
    cfg_ctrl = (32'd1 << 13) | (32'd2 << 8) | (32'd1 << 5) | 32'd3;
    cfg_sta_hi = 32'h3322_1102; cfg_sta_mid = 8'h44; cfg_sta_lo = 8'h55;
    cfg_uc_chan = 3'd4; cfg_uc_mask = 8'h10;
    send_check(48'h5544_3322_1102, "R5 station hit");
    cfg_uc_mask = 8'hEF;
    send_check(48'h5544_3322_1102, "R5 mask cleared");
    cfg_ctrl[21] = 1'b1; cfg_ctrl[18:16] = 3'd7;
    send_check(48'h5544_3322_1102, "R5 masked falls to promisc");
    send_check(48'h5544_3322_1103, "R5 near miss");
    // R6 station wins over broadcast and multicast
    cfg_uc_mask = 8'h10;
    cfg_sta_hi = '1; cfg_sta_mid = '1; cfg_sta_lo = '1;
    send_check(48'hFFFF_FFFF_FFFF, "R6 station over bcast");
    cfg_sta_hi = 32'h3322_1101;
    send_check(48'hFFFF_3322_1101, "R6 station over mcast");

    // R6 random configurations and overlapping addresses
    for (int n = 0; n < 3000; n++) begin
      logic [47:0] a;
      int sel = $urandom_range(0, 7);
      cfg_ctrl = $urandom; cfg_uc_mask = 8'($urandom); cfg_uc_chan = 3'($urandom);
      cfg_sta_hi = $urandom; cfg_sta_mid = 8'($urandom); cfg_sta_lo = 8'($urandom);
      cfg_hash_lo = $urandom; cfg_hash_hi = $urandom;
      a = {16'($urandom), 32'($urandom)};
      if (sel == 0) a = {cfg_sta_lo, cfg_sta_mid, cfg_sta_hi};
      if (sel == 1) a = '1;
      send_check(a, "R6 random");
    end

    // R8 back-pressure
    cfg_ctrl = (32'd1 << 21) | (32'd3 << 16);
    cfg_uc_mask = 8'h00;
    @(negedge clk);
    out_ready = 1'b0; in_dst = 48'h0000_0000_0002; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b1 && out_class === 3'd4, "R8 first result", 32'(out_class), 4);
    cfg_ctrl = 32'd0; in_dst = 48'h0000_0000_0004;
    check(in_ready === 1'b0, "R8 in_ready low in stall", 32'(in_ready), 0);
    @(negedge clk); @(negedge clk);
    check(out_class === 3'd4 && out_chan === 3'd3, "R8 held in stall", 32'(out_chan), 3);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_class === 3'd0 && out_accept === 1'b0,
          "R8 second after drain", 32'(out_class), 0);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", 32'(out_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule